// File: doc/BRIEF.md
# Memory Block Move Engine

This block copies a run of bytes from one region of memory to another over a single-port synchronous memory bus. A command gives a source pointer, a destination pointer, a byte count and a stepping mode. Once the command is taken, the engine runs the whole transfer from its own registers. It reads one byte, writes it, steps both pointers and the count, and repeats until the count runs out. It never goes back to the command between bytes.

The stepping modes cover forward and backward copies. They also cover patterns where one side alternates between two neighbouring addresses, so that a two-location data port can be fed or drained. With a memory that answers at once, timing is fixed: a setup delay, then a constant number of cycles per byte. Any wait cycles the memory adds are added to that per-byte cost.

The memory side is a request/ready handshake. The engine raises `mem_req` with `mem_addr`, `mem_we` and `mem_wdata`, and holds all of them unchanged until the memory raises `mem_ready`. An access completes on a clock edge where both are high. For reads, `mem_rdata` must be valid in that same cycle. The memory applies back-pressure simply by keeping `mem_ready` low; the engine never drops or changes a pending request. The command inputs are plain control pins, sampled on the edge where `start` is high and the engine is idle.

Top module: `blkmove_engine`

## Requirements
- R1: Each byte is read from the current source address and then written, unchanged, to the current destination address. The write of a byte always follows its read.
- R2: Mode 0 steps both pointers up by one after each byte.
- R3: Mode 1 steps both pointers down by one after each byte.
- R4: Mode 2 alternates the source between its start address and start+1 (start address first) and steps the destination up by one.
- R5: Mode 3 steps the source up by one and alternates the destination between its start address and start+1 (start address first).
- R6: Pointers are AW bits wide and wrap modulo 2^AW when stepped. After the transfer, each pointer shows its value after the last step.
- R7: The first read request appears SETUP_CYC clock edges after the edge that takes the command.
- R8: With zero-wait memory, consecutive reads are BYTE_CYC cycles apart and each write completes one cycle after its read. Every wait cycle on a read or a write adds one cycle.
- R9: While `mem_req` is high and `mem_ready` is low, `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` stay unchanged.
- R10: The count drops by one per byte. A start count of 0 moves 2^CW bytes. The engine stops after the write that brings the count to 0, and `count` then reads 0.
- R11: `busy` is high from the edge that takes the command through the edge of the last write. `done` is high for exactly one cycle, right after that edge, while `busy` is low.
- R12: `start` is ignored while `busy` is high. A second command during a transfer changes neither the addresses used, the number of bytes moved, nor the final pointer values.
- R13: After completion, `src_ptr`, `dst_ptr` and `count` hold their values until the next command is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Take the command (only while idle) |
| cmd_src | input | AW | Source start address |
| cmd_dst | input | AW | Destination start address |
| cmd_len | input | CW | Byte count, 0 means 2^CW |
| cmd_mode | input | 2 | Stepping mode 0..3, see R2 to R5 |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| src_ptr | output | AW | Current source pointer |
| dst_ptr | output | AW | Current destination pointer |
| count | output | CW | Bytes remaining |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | AW | Access address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid with mem_ready |
| mem_ready | input | 1 | Access accepted this cycle |

## Verification
The bench builds the engine with AW=16, DW=8, SETUP_CYC=17 and BYTE_CYC=6, but with CW=8. The narrow count makes the start-count-of-zero case (256 bytes) short enough to run in full, while the full-width pointers still let wrap-around at 0xFFFF be seen directly on `mem_addr` and the pointer outputs. The memory model has a programmable number of wait cycles per access. This makes the exact timing reachable in both forms: the fixed setup and per-byte cost with no waits, and the stretched period with waits, where held requests also show the R9 stability rule.

// File: rtl/blkmove_pkg.sv
package blkmove_pkg;

  // Stepping mode as encoded on cmd_mode
  typedef enum logic [1:0] {
    MV_UP       = 2'd0,
    MV_DOWN     = 2'd1,
    MV_SRC_PAIR = 2'd2,
    MV_DST_PAIR = 2'd3
  } mv_mode_e;

  // How one pointer moves after a byte
  typedef enum logic [1:0] {
    ST_INC = 2'd0,
    ST_DEC = 2'd1,
    ST_ALT = 2'd2
  } step_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_SETUP,
    S_RD,
    S_WR,
    S_PAD
  } seq_e;

  function automatic step_e kind_for(input mv_mode_e m, input logic is_dst);
    case (m)
      MV_UP:       kind_for = ST_INC;
      MV_DOWN:     kind_for = ST_DEC;
      MV_SRC_PAIR: kind_for = is_dst ? ST_INC : ST_ALT;
      default:     kind_for = is_dst ? ST_ALT : ST_INC;
    endcase
  endfunction

endpackage

// File: rtl/blkmove_ptr.sv
module blkmove_ptr
  import blkmove_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  step_e         load_kind,
  input  logic          step,
  output logic [AW-1:0] ptr
);

  logic [AW-1:0] base_q;
  logic          phase_q;
  step_e         kind_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr     <= '0;
      base_q  <= '0;
      phase_q <= 1'b0;
      kind_q  <= ST_INC;
    end else if (load) begin
      ptr     <= load_val;
      base_q  <= load_val;
      phase_q <= 1'b0;
      kind_q  <= load_kind;
    end else if (step) begin
      case (kind_q)
        ST_INC: ptr <= ptr + 1'b1;
        ST_DEC: ptr <= ptr - 1'b1;
        default: begin
          ptr     <= phase_q ? base_q : base_q + 1'b1;
          phase_q <= ~phase_q;
        end
      endcase
    end
  end

  // R4 / R5: an alternating pointer only ever sits on its base or base+1
  assert_alt_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_q == ST_ALT) |-> (ptr == base_q || ptr == base_q + 1'b1));

endmodule

// File: rtl/blkmove_cnt.sv
module blkmove_cnt #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          step,
  output logic [CW-1:0] cnt,
  output logic          last
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (load) cnt <= load_val;
    else if (step) cnt <= cnt - 1'b1;
  end

  // A count of 0 is not "last": it wraps and yields 2^CW bytes (R10)
  assign last = (cnt == CW'(1));

endmodule

// File: rtl/blkmove_seq.sv
module blkmove_seq
  import blkmove_pkg::*;
#(
  parameter int SETUP_CYC = 17,
  parameter int BYTE_CYC  = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic mem_ready,
  input  logic last,
  output logic start_ok,
  output logic rd_take,
  output logic step,
  output logic mem_req,
  output logic mem_we,
  output logic busy,
  output logic done
);

  localparam int TMAX = (SETUP_CYC > BYTE_CYC) ? SETUP_CYC : BYTE_CYC;
  localparam int TW   = $clog2(TMAX + 1);
  // Pad cycles after each write so read-to-read spacing equals BYTE_CYC
  localparam logic [TW-1:0] PAD_LOAD   = TW'(BYTE_CYC - 3);
  localparam logic [TW-1:0] SETUP_LOAD = TW'(SETUP_CYC - 1);

  seq_e          state_q;
  logic [TW-1:0] tmr_q;

  assign busy     = (state_q != S_IDLE);
  assign start_ok = start && (state_q == S_IDLE);
  assign mem_req  = (state_q == S_RD) || (state_q == S_WR);
  assign mem_we   = (state_q == S_WR);
  assign rd_take  = (state_q == S_RD) && mem_ready;
  assign step     = (state_q == S_WR) && mem_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      tmr_q   <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state_q)
        S_IDLE: if (start) begin
          state_q <= S_SETUP;
          tmr_q   <= SETUP_LOAD;
        end
        S_SETUP: begin
          if (tmr_q == '0) state_q <= S_RD;
          else             tmr_q   <= tmr_q - 1'b1;
        end
        S_RD: if (mem_ready) state_q <= S_WR;
        S_WR: if (mem_ready) begin
          if (last) begin
            state_q <= S_IDLE;
            done    <= 1'b1;
          end else begin
            state_q <= S_PAD;
            tmr_q   <= PAD_LOAD;
          end
        end
        S_PAD: begin
          if (tmr_q == '0) state_q <= S_RD;
          else             tmr_q   <= tmr_q - 1'b1;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_last_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (step && last) |=> (!busy && done && !mem_req));

endmodule

// File: rtl/blkmove_engine.sv
module blkmove_engine
  import blkmove_pkg::*;
#(
  parameter int AW        = 16,
  parameter int CW        = 16,
  parameter int DW        = 8,
  parameter int SETUP_CYC = 17,
  parameter int BYTE_CYC  = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] cmd_src,
  input  logic [AW-1:0] cmd_dst,
  input  logic [CW-1:0] cmd_len,
  input  logic [1:0]    cmd_mode,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] src_ptr,
  output logic [AW-1:0] dst_ptr,
  output logic [CW-1:0] count,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ready
);

  localparam int NPTR = 2;  // index 0 = source, 1 = destination

  logic          start_ok, rd_take, step, last;
  logic [AW-1:0] ptr_q [NPTR];
  logic [DW-1:0] byte_q;

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    blkmove_ptr #(.AW(AW)) u_ptr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (start_ok),
      .load_val  ((g == 0) ? cmd_src : cmd_dst),
      .load_kind (kind_for(mv_mode_e'(cmd_mode), 1'(g != 0))),
      .step      (step),
      .ptr       (ptr_q[g])
    );
  end

  blkmove_cnt #(.CW(CW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start_ok),
    .load_val (cmd_len),
    .step     (step),
    .cnt      (count),
    .last     (last)
  );

  blkmove_seq #(.SETUP_CYC(SETUP_CYC), .BYTE_CYC(BYTE_CYC)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .mem_ready (mem_ready),
    .last      (last),
    .start_ok  (start_ok),
    .rd_take   (rd_take),
    .step      (step),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .busy      (busy),
    .done      (done)
  );

  // Byte in flight between its read and its write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       byte_q <= '0;
    else if (rd_take) byte_q <= mem_rdata;
  end

  assign src_ptr   = ptr_q[0];
  assign dst_ptr   = ptr_q[1];
  assign mem_addr  = mem_we ? ptr_q[1] : ptr_q[0];
  assign mem_wdata = byte_q;

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) &&
                                 $stable(mem_we) && $stable(mem_wdata)));

  assert_ignore_start_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !mem_ready) |=> (busy && $stable(count)));

  assert_final_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(src_ptr) && $stable(dst_ptr) && $stable(count)));

endmodule

// File: tb/sim_blkmove_engine.sv
module sim_blkmove_engine;

  localparam int AW = 16;
  localparam int CW = 8;
  localparam int DW = 8;
  localparam int SETUP = 17;
  localparam int BYTE = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] cmd_src = '0, cmd_dst = '0;
  logic [CW-1:0] cmd_len = '0;
  logic [1:0]    cmd_mode = '0;
  logic          busy, done, mem_req, mem_we, mem_ready;
  logic [AW-1:0] src_ptr, dst_ptr, mem_addr;
  logic [CW-1:0] count;
  logic [DW-1:0] mem_wdata, mem_rdata;

  always #10 clk = ~clk;

  blkmove_engine #(.AW(AW), .CW(CW), .DW(DW), .SETUP_CYC(SETUP), .BYTE_CYC(BYTE)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_src(cmd_src), .cmd_dst(cmd_dst),
    .cmd_len(cmd_len), .cmd_mode(cmd_mode), .busy(busy), .done(done),
    .src_ptr(src_ptr), .dst_ptr(dst_ptr), .count(count), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready)
  );

  // Memory model: 2 KiB, aliased over the address space, programmable waits
  logic [7:0] mem [0:2047];
  int waitn = 0;
  int wcnt = 0;
  assign mem_ready = mem_req && (wcnt == waitn);
  assign mem_rdata = mem[mem_addr[10:0]];

  always @(posedge clk) begin
    if (mem_req && !mem_ready) wcnt <= wcnt + 1;
    else wcnt <= 0;
    if (mem_req && mem_ready && mem_we) mem[mem_addr[10:0]] <= mem_wdata;
  end

  // Port logger
  int cyc = 0, st_cyc = 0;
  int nrd = 0, nwr = 0, ndone = 0, nbusy = 0, nstab = 0;
  logic log_clr = 1'b0;
  logic [15:0] rd_addr [0:511];
  logic [15:0] wr_addr [0:511];
  logic [7:0]  wr_data [0:511];
  int rd_cyc [0:511];
  int wr_cyc [0:511];
  logic phold = 1'b0, pwe = 1'b0;
  logic [15:0] paddr = '0;
  logic [7:0]  pwd = '0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (start && !busy) st_cyc <= cyc;
    if (log_clr) begin
      nrd <= 0; nwr <= 0; ndone <= 0; nbusy <= 0; nstab <= 0; phold <= 1'b0;
    end else begin
      if (mem_req && mem_ready && !mem_we && nrd < 512) begin
        rd_addr[nrd] <= mem_addr; rd_cyc[nrd] <= cyc; nrd <= nrd + 1;
      end
      if (mem_req && mem_ready && mem_we && nwr < 512) begin
        wr_addr[nwr] <= mem_addr; wr_data[nwr] <= mem_wdata; wr_cyc[nwr] <= cyc;
        nwr <= nwr + 1;
      end
      if (done) ndone <= ndone + 1;
      if (busy) nbusy <= nbusy + 1;
      if (phold && (!mem_req || mem_addr != paddr || mem_we != pwe || mem_wdata != pwd))
        nstab <= nstab + 1;
      phold <= mem_req && !mem_ready;
      paddr <= mem_addr; pwe <= mem_we; pwd <= mem_wdata;
    end
  end

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Mode encoding: 0 up/up, 1 down/down, 2 src pair/dst up, 3 src up/dst pair
  function automatic int kind_of(input logic [1:0] m, input bit is_dst);
    case (m)
      2'd0: return 0;
      2'd1: return 1;
      2'd2: return is_dst ? 0 : 2;
      default: return is_dst ? 2 : 0;
    endcase
  endfunction

  function automatic logic [15:0] addr_at(input logic [15:0] b, input int kind, input int k);
    case (kind)
      0: return b + 16'(k);
      1: return b - 16'(k);
      default: return b + 16'(k & 1);
    endcase
  endfunction

  task automatic run_cmd(input string tag, input logic [15:0] s, input logic [15:0] d,
                         input logic [7:0] len, input logic [1:0] m, input int w,
                         input bit poke);
    int n, t, bad, badd, badt;
    logic [7:0] expd [0:511];
    logic [15:0] fs, fd;
    logic [7:0] fc;
    n = (len == 0) ? 256 : int'(len);
    for (int k = 0; k < n; k++) expd[k] = mem[addr_at(s, kind_of(m, 0), k) & 16'h07FF];
    waitn = w;
    @(negedge clk); log_clr = 1'b1;
    @(negedge clk); log_clr = 1'b0;
    cmd_src = s; cmd_dst = d; cmd_len = len; cmd_mode = m; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy == 1'b1, "R11", {tag, " busy after start"}, busy, 1);
    if (poke) begin
      repeat (20) @(negedge clk);
      cmd_src = 16'h0700; cmd_dst = 16'h0680; cmd_len = 8'd2; cmd_mode = 2'd1;
      start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    t = 0;
    while (ndone == 0 && t < 5000) begin @(negedge clk); t++; end
    repeat (3) @(negedge clk);
    chk(nrd == n && nwr == n, "R10", {tag, " bytes moved"}, nwr, n);
    bad = -1; badd = -1; badt = -1;
    for (int k = 0; k < n && k < nwr; k++) begin
      if (bad < 0 && (rd_addr[k] != addr_at(s, kind_of(m, 0), k) ||
                      wr_addr[k] != addr_at(d, kind_of(m, 1), k))) bad = k;
      if (badd < 0 && wr_data[k] != expd[k]) badd = k;
      if (badt < 0 && (rd_cyc[k] != st_cyc + SETUP + 1 + w + k * (BYTE + 2 * w) ||
                       wr_cyc[k] != rd_cyc[k] + 1 + w)) badt = k;
    end
    chk(bad < 0, tag, "address sequence, first bad byte", bad, -1);
    chk(badd < 0, "R1", {tag, " copied data, first bad byte"}, badd, -1);
    chk(rd_cyc[0] - st_cyc == SETUP + 1 + w, "R7", {tag, " setup latency"},
        rd_cyc[0] - st_cyc, SETUP + 1 + w);
    chk(badt < 0, "R8", {tag, " per-byte timing, first bad byte"}, badt, -1);
    chk(nstab == 0, "R9", {tag, " held request changes"}, nstab, 0);
    fs = addr_at(s, kind_of(m, 0), n);
    fd = addr_at(d, kind_of(m, 1), n);
    chk(src_ptr == fs, tag, "final source pointer", src_ptr, fs);
    chk(dst_ptr == fd, tag, "final destination pointer", dst_ptr, fd);
    chk(count == 0, "R10", {tag, " final count"}, count, 0);
    chk(ndone == 1 && !busy, "R11", {tag, " done pulses"}, ndone, 1);
    chk(nbusy == wr_cyc[n-1] - st_cyc, "R11", {tag, " busy length"},
        nbusy, wr_cyc[n-1] - st_cyc);
    fs = src_ptr; fd = dst_ptr; fc = count;
    repeat (5) @(negedge clk);
    chk(src_ptr == fs && dst_ptr == fd && count == fc && !mem_req, "R13",
        {tag, " state held after done"}, src_ptr, fs);
  endtask

  task automatic t_reset;
    chk(!busy && !done && !mem_req, "R11", "reset idle state", {busy, done, mem_req}, 0);
    chk(count == 0 && src_ptr == 0, "R13", "reset pointer and count", count, 0);
  endtask

  task automatic t_up;        run_cmd("R2", 16'h0010, 16'h0200, 8'd5, 2'd0, 0, 1'b0); endtask
  task automatic t_down;      run_cmd("R3", 16'h0060, 16'h0260, 8'd4, 2'd1, 0, 1'b0); endtask
  task automatic t_src_pair;  run_cmd("R4", 16'h0080, 16'h0300, 8'd5, 2'd2, 0, 1'b0); endtask
  task automatic t_dst_pair;  run_cmd("R5", 16'h0090, 16'h0320, 8'd6, 2'd3, 0, 1'b0); endtask
  task automatic t_waits;     run_cmd("R8", 16'h00A0, 16'h0340, 8'd3, 2'd0, 2, 1'b0); endtask
  task automatic t_wrap;
    run_cmd("R6", 16'hFFFE, 16'h0380, 8'd4, 2'd0, 0, 1'b0);
    run_cmd("R6", 16'h0001, 16'h03C0, 8'd4, 2'd1, 1, 1'b0);
  endtask
  task automatic t_zero;      run_cmd("R10", 16'h0100, 16'h0400, 8'd0, 2'd0, 0, 1'b0); endtask
  task automatic t_busy_start; run_cmd("R12", 16'h00C0, 16'h0500, 8'd6, 2'd0, 0, 1'b1); endtask

  initial begin
    for (int i = 0; i < 2048; i++) mem[i] = 8'((i * 37 + 11) ^ (i >> 5));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_up();
    t_down();
    t_src_pair();
    t_dst_pair();
    t_waits();
    t_wrap();
    t_zero();
    t_busy_start();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule